// File: doc/BRIEF.md
# Byte-Window 16-bit Memory Access Engine

This block gives an 8-bit host bus access to a 16-bit external memory (flash or pseudo-static RAM) through a small window of byte registers. The host sets a memory-control byte, loads a 24-bit byte address through three address registers, and moves data through a low and a high data register. Any host access to the low data register starts one external memory transaction. A read returns the low byte at once and keeps the high byte for a later read. A write sends the previously staged high byte together with the newly written low byte.

External timing is a fixed count of wait cycles. For that many clock cycles the selected chip enable and either the output enable or the write enable are held low. The host acknowledge is withheld until the transaction has finished. When auto-increment is on, the address advances by one 16-bit word after every triggered transaction.

The sequencer has three states:
- `ST_IDLE`: waiting for a host request.
- `ST_XFER`: external strobes asserted and the wait-cycle counter running.
- `ST_ACK`: a one-cycle host acknowledge.

Its transitions are:
- register access: `ST_IDLE` → `ST_ACK`
- trigger: `ST_IDLE` → `ST_XFER`, on a request at the low data offset
- count: `ST_XFER` → `ST_XFER`
- finish: `ST_XFER` → `ST_ACK`, on the last wait cycle
- release: `ST_ACK` → `ST_IDLE`

Top module: `memwin16_engine`

## Requirements
- R1: After reset the control byte reads 0xC4 and the address and data registers read 0. Both chip enables, the output enable and the write enable are high, `flash_rst_n` is 1, `ram_cre` is 0 and `hb_ack` is 0.
- R2: The host offsets are: 0 for control, 1, 2 and 3 for address bits 7:0, 15:8 and 23:16, 4 for data low and 5 for data high. Writes to offsets 0–3 store the value and reads return it. Offsets 6 and 7 read 0 and ignore writes. A non-triggering access is acknowledged in the cycle after the request.
- R3: Control bit 7 drives `flash_rst_n` and control bit 1 drives `ram_cre` directly. During a transaction, control bit 6 low selects flash (`flash_ce_n` low) and control bit 2 low selects RAM (`ram_ce_n` low).
- R4: `mem_addr` presents byte-address bits 23:1. Address bit 0 does not reach the memory.
- R5: A host read of offset 4 holds `mem_oe_n` low for exactly WAIT_CYC cycles, with `mem_we_n` high and `mem_dout_en` low. It returns `mem_din[7:0]` and latches `mem_din[15:8]`. A following read of offset 5 returns that byte without a new transaction.
- R6: A host write of offset 5 only stages the byte and causes no strobe. A host write of offset 4 holds `mem_we_n` low and `mem_dout_en` high for exactly WAIT_CYC cycles, with `mem_dout` = {staged high byte, new low byte}.
- R7: With control bit 0 set, the 24-bit address increases by 2 after each triggered transaction and wraps from 0xFFFFFE to 0. With bit 0 clear it is unchanged.
- R8: For a triggered access, `hb_ack` rises in the cycle after the last strobe cycle, which is WAIT_CYC+1 cycles after the request. `hb_ack` never stays high for two consecutive cycles.
- R9: Outside a triggered transaction both chip enables, `mem_oe_n` and `mem_we_n` are high and `mem_dout_en` is low. `mem_oe_n` and `mem_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_cyc | input | 1 | Host bus cycle |
| hb_stb | input | 1 | Host bus strobe |
| hb_we | input | 1 | Host bus write |
| hb_adr | input | 3 | Host register offset |
| hb_wdat | input | 8 | Host write data |
| hb_rdat | output | 8 | Host read data |
| hb_ack | output | 1 | Host acknowledge |
| mem_addr | output | 23 | External word address (byte address bits 23:1) |
| mem_din | input | 16 | Data from external memory |
| mem_dout | output | 16 | Data to external memory |
| mem_dout_en | output | 1 | Drive enable for `mem_dout` |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| flash_rst_n | output | 1 | Flash reset, active low |
| ram_cre | output | 1 | RAM configuration enable |

## Verification
The hardest case to reach is the address wrap on auto-increment. It needs the top address byte loaded to 0xFF and the low byte to 0xFE before a triggered write. The bench loads all three address registers through the window, triggers one transaction, and reads the three bytes back as zero. The ordering that makes a high-byte read free of strobes is also subtle. The bench counts strobe cycles with a monitor between the low-byte trigger and the high-byte read, so a stray second transaction shows up.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
    localparam int BYTE_W    = 8;
    localparam int HB_AW     = 3;
    localparam int MEM_AW    = 24;
    localparam int MEM_DW    = 16;
    localparam int ADR_BYTES = MEM_AW / BYTE_W;

    localparam logic [HB_AW-1:0] OFS_CTRL  = 3'd0;
    localparam logic [HB_AW-1:0] OFS_ADR_L = 3'd1;
    localparam logic [HB_AW-1:0] OFS_DAT_L = 3'd4;
    localparam logic [HB_AW-1:0] OFS_DAT_H = 3'd5;

    localparam int CB_FRST = 7;
    localparam int CB_FSEL = 6;
    localparam int CB_RSEL = 2;
    localparam int CB_CRE  = 1;
    localparam int CB_AINC = 0;

    localparam logic [BYTE_W-1:0] CTRL_RESET = 8'hC4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_ACK
    } seq_state_t;
endpackage

// File: rtl/memwin_seq.sv
module memwin_seq
    import memwin_pkg::*;
#(
    parameter int WAIT_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic req_i,
    input  logic trig_i,
    input  logic we_i,
    output logic start_o,
    output logic regacc_o,
    output logic done_o,
    output logic active_o,
    output logic ack_o,
    output logic op_wr_o
);
    localparam int CNT_W = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYC - 1);

    seq_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             op_wr_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            op_wr_q <= 1'b0;
        end else if (start_o) begin
            cnt_q   <= '0;
            op_wr_q <= we_i;
        end else if (state_q == ST_XFER) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d  = state_q;
        start_o  = 1'b0;
        regacc_o = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_i && trig_i) begin
                    start_o = 1'b1;
                    state_d = ST_XFER;
                end else if (req_i) begin
                    regacc_o = 1'b1;
                    state_d  = ST_ACK;
                end
            end
            ST_XFER: begin
                if (cnt_q == CNT_LAST) begin
                    done_o  = 1'b1;
                    state_d = ST_ACK;
                end
            end
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign active_o = (state_q == ST_XFER);
    assign ack_o    = (state_q == ST_ACK);
    assign op_wr_o  = op_wr_q;

    // R8: acknowledge is a single-cycle pulse
    a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);
    // R8: end of strobes is followed at once by the acknowledge
    a_r8_ack_after_xfer: assert property (@(posedge clk) disable iff (rst)
        $fell(active_o) |-> ack_o);
    // R5/R6: strobe window never exceeds the wait count
    a_r5_window: assert property (@(posedge clk) disable iff (rst)
        active_o |-> (cnt_q <= CNT_LAST));
endmodule

// File: rtl/memwin_regs.sv
module memwin_regs
    import memwin_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 regacc_i,
    input  logic                 start_i,
    input  logic                 done_i,
    input  logic                 we_i,
    input  logic                 op_wr_i,
    input  logic [HB_AW-1:0]     adr_i,
    input  logic [BYTE_W-1:0]    wdat_i,
    input  logic [MEM_DW-1:0]    mem_din_i,
    output logic [BYTE_W-1:0]    ctrl_o,
    output logic [MEM_AW-1:0]    addr_o,
    output logic [MEM_DW-1:0]    wdata_o,
    output logic [BYTE_W-1:0]    rdat_o
);
    logic [BYTE_W-1:0] ctrl_q, dlo_q, dhi_q, rdat_q, rd_mux;
    logic [MEM_AW-1:0] addr_q;

    always_comb begin
        rd_mux = '0;
        if (adr_i == OFS_CTRL)  rd_mux = ctrl_q;
        if (adr_i == OFS_DAT_L) rd_mux = dlo_q;
        if (adr_i == OFS_DAT_H) rd_mux = dhi_q;
        for (int i = 0; i < ADR_BYTES; i++) begin
            if (adr_i == OFS_ADR_L + HB_AW'(i)) rd_mux = addr_q[i*BYTE_W +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RESET;
            addr_q <= '0;
            dlo_q  <= '0;
            dhi_q  <= '0;
            rdat_q <= '0;
        end else begin
            if (regacc_i) begin
                rdat_q <= rd_mux;
                if (we_i) begin
                    if (adr_i == OFS_CTRL)  ctrl_q <= wdat_i;
                    if (adr_i == OFS_DAT_H) dhi_q  <= wdat_i;
                    for (int i = 0; i < ADR_BYTES; i++) begin
                        if (adr_i == OFS_ADR_L + HB_AW'(i))
                            addr_q[i*BYTE_W +: BYTE_W] <= wdat_i;
                    end
                end
            end
            if (start_i && we_i) dlo_q <= wdat_i;
            if (done_i) begin
                if (!op_wr_i) begin
                    dlo_q  <= mem_din_i[BYTE_W-1:0];
                    dhi_q  <= mem_din_i[MEM_DW-1:BYTE_W];
                    rdat_q <= mem_din_i[BYTE_W-1:0];
                end else begin
                    rdat_q <= dlo_q;
                end
                if (ctrl_q[CB_AINC]) addr_q <= addr_q + MEM_AW'(2);
            end
        end
    end

    assign ctrl_o  = ctrl_q;
    assign addr_o  = addr_q;
    assign wdata_o = {dhi_q, dlo_q};
    assign rdat_o  = rdat_q;

    // R7: auto-increment steps by one word, modulo the address space
    a_r7_autoinc: assert property (@(posedge clk) disable iff (rst)
        (done_i && ctrl_q[CB_AINC]) |=> (addr_q == $past(addr_q) + MEM_AW'(2)));
    // R7: without auto-increment the address holds across a transaction
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (done_i && !ctrl_q[CB_AINC]) |=> $stable(addr_q));
endmodule

// File: rtl/memwin_pins.sv
module memwin_pins
    import memwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  logic              op_wr_i,
    input  logic [BYTE_W-1:0] ctrl_i,
    input  logic [MEM_AW-1:0] addr_i,
    input  logic [MEM_DW-1:0] wdata_i,
    output logic [MEM_AW-2:0] mem_addr,
    output logic [MEM_DW-1:0] mem_dout,
    output logic              mem_dout_en,
    output logic              flash_ce_n,
    output logic              ram_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              flash_rst_n,
    output logic              ram_cre
);
    always_comb begin
        mem_addr    = addr_i[MEM_AW-1:1];
        mem_dout    = wdata_i;
        flash_ce_n  = !(active_i && !ctrl_i[CB_FSEL]);
        ram_ce_n    = !(active_i && !ctrl_i[CB_RSEL]);
        mem_oe_n    = !(active_i && !op_wr_i);
        mem_we_n    = !(active_i && op_wr_i);
        mem_dout_en = active_i && op_wr_i;
        flash_rst_n = ctrl_i[CB_FRST];
        ram_cre     = ctrl_i[CB_CRE];
    end

    // R9: strobes stay quiet when no transaction runs
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !active_i |-> (flash_ce_n && ram_ce_n && mem_oe_n && mem_we_n && !mem_dout_en));
    // R9: read and write enables are exclusive
    a_r9_oe_we_excl: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n));
    // R6: data is driven only while the write strobe is low
    a_r6_drive_on_write: assert property (@(posedge clk) disable iff (rst)
        mem_dout_en |-> !mem_we_n);
endmodule

// File: rtl/memwin16_engine.sv
module memwin16_engine
    import memwin_pkg::*;
#(
    parameter int WAIT_CYC = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        hb_cyc,
    input  logic        hb_stb,
    input  logic        hb_we,
    input  logic [2:0]  hb_adr,
    input  logic [7:0]  hb_wdat,
    output logic [7:0]  hb_rdat,
    output logic        hb_ack,
    output logic [22:0] mem_addr,
    input  logic [15:0] mem_din,
    output logic [15:0] mem_dout,
    output logic        mem_dout_en,
    output logic        flash_ce_n,
    output logic        ram_ce_n,
    output logic        mem_oe_n,
    output logic        mem_we_n,
    output logic        flash_rst_n,
    output logic        ram_cre
);
    logic              start, regacc, done, active, op_wr;
    logic [BYTE_W-1:0] ctrl;
    logic [MEM_AW-1:0] addr;
    logic [MEM_DW-1:0] wdata;

    memwin_seq #(.WAIT_CYC(WAIT_CYC)) seq_i (
        .clk(clk), .rst(rst),
        .req_i(hb_cyc && hb_stb), .trig_i(hb_adr == OFS_DAT_L), .we_i(hb_we),
        .start_o(start), .regacc_o(regacc), .done_o(done),
        .active_o(active), .ack_o(hb_ack), .op_wr_o(op_wr)
    );

    memwin_regs regs_i (
        .clk(clk), .rst(rst),
        .regacc_i(regacc), .start_i(start), .done_i(done),
        .we_i(hb_we), .op_wr_i(op_wr), .adr_i(hb_adr), .wdat_i(hb_wdat),
        .mem_din_i(mem_din),
        .ctrl_o(ctrl), .addr_o(addr), .wdata_o(wdata), .rdat_o(hb_rdat)
    );

    memwin_pins pins_i (
        .clk(clk), .rst(rst),
        .active_i(active), .op_wr_i(op_wr), .ctrl_i(ctrl),
        .addr_i(addr), .wdata_i(wdata),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_en(mem_dout_en),
        .flash_ce_n(flash_ce_n), .ram_ce_n(ram_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .flash_rst_n(flash_rst_n), .ram_cre(ram_cre)
    );
endmodule

// File: tb/memwin16_engine_tb_top.sv
`timescale 1ns/1ps
module memwin16_engine_tb_top;
    localparam int WAIT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hb_cyc = 1'b0, hb_stb = 1'b0, hb_we = 1'b0;
    logic [2:0]  hb_adr = '0;
    logic [7:0]  hb_wdat = '0;
    logic [7:0]  hb_rdat;
    logic        hb_ack;
    logic [22:0] mem_addr;
    logic [15:0] mem_din, mem_dout;
    logic        mem_dout_en, flash_ce_n, ram_ce_n, mem_oe_n, mem_we_n, flash_rst_n, ram_cre;

    int n_chk = 0, n_bad = 0;
    int oe_cnt = 0, we_cnt = 0, den_cnt = 0, fce_cnt = 0, rce_cnt = 0, idle_viol = 0, ack_dbl = 0;
    logic        ack_prev = 1'b0;
    logic [15:0] last_dout = '0;
    logic [22:0] last_rd_addr = '0;

    always #10 clk = ~clk;

    // memory model: data word is a function of the word address
    assign mem_din = {mem_addr[7:0] ^ 8'h5A, mem_addr[15:8] ^ 8'hC3};

    memwin16_engine #(.WAIT_CYC(WAIT)) dut_i (
        .clk(clk), .rst(rst), .hb_cyc(hb_cyc), .hb_stb(hb_stb), .hb_we(hb_we),
        .hb_adr(hb_adr), .hb_wdat(hb_wdat), .hb_rdat(hb_rdat), .hb_ack(hb_ack),
        .mem_addr(mem_addr), .mem_din(mem_din), .mem_dout(mem_dout),
        .mem_dout_en(mem_dout_en), .flash_ce_n(flash_ce_n), .ram_ce_n(ram_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .flash_rst_n(flash_rst_n), .ram_cre(ram_cre)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_oe_n) begin oe_cnt++; last_rd_addr = mem_addr; end
            if (!mem_we_n) begin we_cnt++; last_dout = mem_dout; end
            if (mem_dout_en) den_cnt++;
            if (!flash_ce_n) fce_cnt++;
            if (!ram_ce_n) rce_cnt++;
            if ((!flash_ce_n || !ram_ce_n || mem_dout_en) && mem_oe_n && mem_we_n) idle_viol++;
            if (!mem_oe_n && !mem_we_n) idle_viol++;
            if (hb_ack && ack_prev) ack_dbl++;
            ack_prev = hb_ack;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] q, output int lat);
        @(negedge clk);
        hb_cyc = 1'b1; hb_stb = 1'b1; hb_we = we; hb_adr = a; hb_wdat = d;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!hb_ack && lat < 100);
        q = hb_rdat;
        hb_cyc = 1'b0; hb_stb = 1'b0; hb_we = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] q; int lat;
        xfer(1'b1, a, d, q, lat);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] q);
        int lat;
        xfer(1'b0, a, 8'h00, q, lat);
    endtask

    task automatic set_addr(input logic [23:0] a);
        wr(3'd1, a[7:0]); wr(3'd2, a[15:8]); wr(3'd3, a[23:16]);
    endtask

    task automatic t_reset;
        logic [7:0] q;
        chk("R1 flash_ce_n", flash_ce_n, 1);
        chk("R1 ram_ce_n", ram_ce_n, 1);
        chk("R1 oe/we", {mem_oe_n, mem_we_n}, 2'b11);
        chk("R1 flash_rst_n", flash_rst_n, 1);
        chk("R1 ram_cre", ram_cre, 0);
        chk("R1 ack", hb_ack, 0);
        rd(3'd0, q); chk("R1 ctrl", q, 8'hC4);
        for (int i = 1; i < 6; i++) begin
            if (i != 4) begin rd(3'(i), q); chk("R1 reg zero", q, 0); end
        end
    endtask

    task automatic t_regs;
        logic [7:0] q; int lat;
        set_addr(24'hA5C3_3C);
        rd(3'd1, q); chk("R2 addr L", q, 8'h3C);
        rd(3'd2, q); chk("R2 addr M", q, 8'hC3);
        rd(3'd3, q); chk("R2 addr H", q, 8'hA5);
        xfer(1'b1, 3'd6, 8'h77, q, lat); chk("R2 reg latency", lat, 1);
        rd(3'd6, q); chk("R2 offset 6 reads 0", q, 0);
        rd(3'd7, q); chk("R2 offset 7 reads 0", q, 0);
        rd(3'd1, q); chk("R2 addr after ignored write", q, 8'h3C);
    endtask

    task automatic t_ctrl_pins;
        logic [7:0] q;
        wr(3'd0, 8'h46);
        chk("R3 flash_rst_n low", flash_rst_n, 0);
        chk("R3 ram_cre high", ram_cre, 1);
        chk("R9 ce idle", {flash_ce_n, ram_ce_n}, 2'b11);
        rd(3'd0, q); chk("R2 ctrl readback", q, 8'h46);
        wr(3'd0, 8'hC4);
        chk("R3 flash_rst_n high", flash_rst_n, 1);
    endtask

    task automatic t_read_flash;
        logic [7:0] q; int lat; int oe0, we0, f0, r0;
        logic [15:0] expw;
        wr(3'd0, 8'h84);
        set_addr(24'h01_2345);
        expw = {8'hA2 ^ 8'h5A, 8'h91 ^ 8'hC3};
        oe0 = oe_cnt; we0 = we_cnt; f0 = fce_cnt; r0 = rce_cnt;
        xfer(1'b0, 3'd4, 8'h00, q, lat);
        chk("R5 low byte", q, expw[7:0]);
        chk("R8 trigger latency", lat, WAIT + 1);
        chk("R5 oe cycles", oe_cnt - oe0, WAIT);
        chk("R5 no write strobe", we_cnt - we0, 0);
        chk("R3 flash selected", fce_cnt - f0, WAIT);
        chk("R3 ram not selected", rce_cnt - r0, 0);
        chk("R4 word address", last_rd_addr, 23'h0091A2);
        oe0 = oe_cnt;
        xfer(1'b0, 3'd5, 8'h00, q, lat);
        chk("R5 high byte latched", q, expw[15:8]);
        chk("R5 high read no strobe", oe_cnt - oe0, 0);
        rd(3'd1, q); chk("R7 no increment when off", q, 8'h45);
    endtask

    task automatic t_write_ram;
        logic [7:0] q; int lat; int we0, d0, f0, r0, oe0;
        wr(3'd0, 8'hC0);
        set_addr(24'h00_0200);
        we0 = we_cnt;
        wr(3'd5, 8'hBE);
        chk("R6 stage only", we_cnt - we0, 0);
        we0 = we_cnt; d0 = den_cnt; f0 = fce_cnt; r0 = rce_cnt; oe0 = oe_cnt;
        xfer(1'b1, 3'd4, 8'hEF, q, lat);
        chk("R6 we cycles", we_cnt - we0, WAIT);
        chk("R6 drive cycles", den_cnt - d0, WAIT);
        chk("R6 write word", last_dout, 16'hBEEF);
        chk("R3 ram selected", rce_cnt - r0, WAIT);
        chk("R3 flash not selected", fce_cnt - f0, 0);
        chk("R6 no read strobe", oe_cnt - oe0, 0);
        chk("R8 write latency", lat, WAIT + 1);
    endtask

    task automatic t_autoinc;
        logic [7:0] q;
        wr(3'd0, 8'hC1);
        set_addr(24'h00_0011);
        rd(3'd4, q);
        chk("R4 bit0 ignored", last_rd_addr, 23'h8);
        rd(3'd1, q); chk("R7 step 1", q, 8'h13);
        rd(3'd4, q);
        chk("R7 next word", last_rd_addr, 23'h9);
        rd(3'd1, q); chk("R7 step 2", q, 8'h15);
        set_addr(24'hFF_FFFE);
        wr(3'd4, 8'h01);
        rd(3'd1, q); chk("R7 wrap L", q, 8'h00);
        rd(3'd2, q); chk("R7 wrap M", q, 8'h00);
        rd(3'd3, q); chk("R7 wrap H", q, 8'h00);
        wr(3'd0, 8'hC4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_regs;
        t_ctrl_pins;
        t_read_flash;
        t_write_ram;
        t_autoinc;
        repeat (2) @(negedge clk);
        chk("R9 idle strobes", idle_viol, 0);
        chk("R8 ack single", ack_dbl, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule